// File: doc/BRIEF.md
# GPIO Set/Clear Register Controller

This block is a register-mapped controller for a bank of general-purpose I/O pins. It has 54 pins by default. Software reaches it over a simple synchronous bus that moves one 32-bit word per access. The bus has a write strobe, a read strobe, a word address, write data and read data.

Each pin has a 3-bit function code. The code decides whether the pin drives its output. The drive value of a pin comes from an output latch. Software never writes that latch directly. It writes a one into a set word or a clear word, so a single bit can change without a read-modify-write sequence.

The latch still follows set and clear writes while its pin is an input. The pin shows the held value as soon as software turns the pin into an output. The pin inputs pass through a synchronizer, and software reads the result back as level words.

Top module: `gpio_setclr_ctrl`

## Requirements
- R1: After reset, all function codes are 000 (input) and all output latches are 0. `pin_oe`, `pin_out` and `bus_rdata` are all zero.
- R2: The function code of pin n is at word address n/10 (byte offset 4*(n/10)), in bits 3*(n mod 10)+2 down to 3*(n mod 10). A read returns the stored codes. Bits 31:30, and the fields of pins beyond the last pin, read as zero.
- R3: `pin_oe[n]` is 1 exactly when the function code of pin n is 001. Codes 000 and 010 to 111 leave the pin undriven.
- R4: A write to a set word sets the output latch of every pin whose bit is 1. The set word for pins 0 to 31 (bit n) is at word 7 (byte 0x1C). The set word for pins 32 and up (bit n-32) is at word 8 (byte 0x20). Zero bits have no effect.
- R5: A write to a clear word clears the output latch of every pin whose bit is 1. The clear word for pins 0 to 31 is at word 10 (byte 0x28). The clear word for pins 32 and up is at word 11 (byte 0x2C). Zero bits have no effect.
- R6: Reads of the set and clear words return zero.
- R7: `pin_out[n]` equals the latch of pin n while the pin is an output, and is 0 otherwise. The latch keeps following set and clear writes while the pin is an input. Once the pin becomes an output, it shows the latch value left by those writes.
- R8: The level words at word 13 (byte 0x34, pins 0 to 31) and word 14 (byte 0x38, pins 32 and up) return `pin_in` after a two-flop synchronizer. Bits beyond the last pin read as zero. A change of `pin_in` first shows in a read whose strobe is sampled on the third rising edge after the change.
- R9: `bus_rdata` is registered. It carries the addressed word one cycle after `bus_re` and holds its value while `bus_re` is low.
- R10: Reads of unmapped word addresses (6, 9, 12 and 15 and above) return zero. Writes to them change no register and no pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_addr | input | ADDR_W (6) | Word address (byte offset / 4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | NUM_PINS (54) | Raw pin input levels |
| pin_out | output | NUM_PINS (54) | Pin drive value, 0 when not driven |
| pin_oe | output | NUM_PINS (54) | Pin drive enable |

## Verification
The bench builds the block with its default parameters: 54 pins, a 6-bit word address and two synchronizer stages. A 54-pin bank is small enough to sweep every pin through all eight function codes with a readback after each write. It also walks a single set bit and then a single clear bit across every pin. The partially filled last function word and the 22-bit second bank are where field masking and out-of-range bits show up.

Every unmapped address in a spread across the 64-word space is written with all ones and read back. The level path is timed cycle by cycle against the synchronizer depth.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int DATA_W       = 32;
    localparam int FIELD_W      = 3;
    localparam int PINS_PER_SEL = 10;

    localparam logic [FIELD_W-1:0] FN_INPUT  = 3'b000;
    localparam logic [FIELD_W-1:0] FN_OUTPUT = 3'b001;

    // word indices of the register groups (byte offset / 4)
    localparam int SEL_BASE_W = 0;
    localparam int SET_BASE_W = 7;
    localparam int CLR_BASE_W = 10;
    localparam int LVL_BASE_W = 13;

    typedef enum logic [2:0] {
        RK_NONE,
        RK_SEL,
        RK_SET,
        RK_CLR,
        RK_LVL
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e  kind;
        logic [2:0] idx;
    } reg_sel_t;

    function automatic int sel_regs(input int n);
        return (n + PINS_PER_SEL - 1) / PINS_PER_SEL;
    endfunction

    function automatic int bank_regs(input int n);
        return (n + DATA_W - 1) / DATA_W;
    endfunction

    function automatic int field_lsb(input int pin);
        return FIELD_W * (pin % PINS_PER_SEL);
    endfunction

endpackage

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
    import gpio_pkg::*;
#(
    parameter int NUM_PINS = 54,
    parameter int ADDR_W   = 6
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_t          sel
);
    localparam int N_SEL  = sel_regs(NUM_PINS);
    localparam int N_BANK = bank_regs(NUM_PINS);

    always_comb begin
        int a;
        a        = int'(addr);
        sel.kind = RK_NONE;
        sel.idx  = '0;
        if (a >= SEL_BASE_W && a < SEL_BASE_W + N_SEL) begin
            sel.kind = RK_SEL;
            sel.idx  = 3'(a - SEL_BASE_W);
        end else if (a >= SET_BASE_W && a < SET_BASE_W + N_BANK) begin
            sel.kind = RK_SET;
            sel.idx  = 3'(a - SET_BASE_W);
        end else if (a >= CLR_BASE_W && a < CLR_BASE_W + N_BANK) begin
            sel.kind = RK_CLR;
            sel.idx  = 3'(a - CLR_BASE_W);
        end else if (a >= LVL_BASE_W && a < LVL_BASE_W + N_BANK) begin
            sel.kind = RK_LVL;
            sel.idx  = 3'(a - LVL_BASE_W);
        end
    end

endmodule

// File: rtl/gpio_fsel_bank.sv
module gpio_fsel_bank
    import gpio_pkg::*;
#(
    parameter int NUM_PINS = 54
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  reg_sel_t            sel,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   rd_word,
    output logic [NUM_PINS-1:0] drive_en
);
    logic [FIELD_W-1:0] code_q [NUM_PINS];
    logic               sel_hit;
    logic               unused_wdata;

    assign sel_hit      = wr_en && (sel.kind == RK_SEL);
    assign unused_wdata = ^wdata;

    always_ff @(posedge clk) begin
        for (int p = 0; p < NUM_PINS; p++) begin
            if (rst) begin
                code_q[p] <= FN_INPUT;
            end else if (sel_hit && int'(sel.idx) == p / PINS_PER_SEL) begin
                code_q[p] <= wdata[field_lsb(p) +: FIELD_W];
            end
        end
    end

    always_comb begin
        rd_word = '0;
        for (int p = 0; p < NUM_PINS; p++) begin
            if (int'(sel.idx) == p / PINS_PER_SEL) begin
                rd_word[field_lsb(p) +: FIELD_W] = code_q[p];
            end
        end
    end

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        localparam int REG_I = p / PINS_PER_SEL;
        localparam int LSB_I = FIELD_W * (p % PINS_PER_SEL);

        assign drive_en[p] = (code_q[p] == FN_OUTPUT);

        // R3
        oe_on_write_chk: assert property (@(posedge clk) disable iff (rst)
            (wr_en && sel.kind == RK_SEL && int'(sel.idx) == REG_I)
            |=> (drive_en[p] == ($past(wdata[LSB_I +: FIELD_W]) == FN_OUTPUT)));
    end

endmodule

// File: rtl/gpio_out_latch.sv
module gpio_out_latch
    import gpio_pkg::*;
#(
    parameter int NUM_PINS = 54
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  reg_sel_t            sel,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [NUM_PINS-1:0] drive_en,
    output logic [NUM_PINS-1:0] pin_out
);
    logic [NUM_PINS-1:0] latch_q;
    logic [NUM_PINS-1:0] set_mask;
    logic [NUM_PINS-1:0] clr_mask;

    always_comb begin
        for (int p = 0; p < NUM_PINS; p++) begin
            set_mask[p] = wr_en && sel.kind == RK_SET
                       && int'(sel.idx) == p / DATA_W && wdata[p % DATA_W];
            clr_mask[p] = wr_en && sel.kind == RK_CLR
                       && int'(sel.idx) == p / DATA_W && wdata[p % DATA_W];
        end
    end

    // set and clear never target the same word, so their order is free
    always_ff @(posedge clk) begin
        if (rst) begin
            latch_q <= '0;
        end else begin
            latch_q <= (latch_q | set_mask) & ~clr_mask;
        end
    end

    assign pin_out = latch_q & drive_en;

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        localparam int BANK_I = p / DATA_W;
        localparam int BIT_I  = p % DATA_W;

        // R4
        set_one_chk: assert property (@(posedge clk) disable iff (rst)
            (wr_en && sel.kind == RK_SET && int'(sel.idx) == BANK_I && wdata[BIT_I])
            |=> latch_q[p]);

        // R4
        set_zero_chk: assert property (@(posedge clk) disable iff (rst)
            (wr_en && sel.kind == RK_SET && int'(sel.idx) == BANK_I && !wdata[BIT_I])
            |=> $stable(latch_q[p]));

        // R5
        clr_one_chk: assert property (@(posedge clk) disable iff (rst)
            (wr_en && sel.kind == RK_CLR && int'(sel.idx) == BANK_I && wdata[BIT_I])
            |=> !latch_q[p]);
    end

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int WIDTH  = 54,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) begin
                stage_q[s] <= '0;
            end
        end else begin
            stage_q[0] <= din;
            for (int s = 1; s < STAGES; s++) begin
                stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign dout = stage_q[STAGES-1];

    // R8
    sync_first_stage_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (stage_q[0] == $past(din)));

endmodule

// File: rtl/gpio_setclr_ctrl.sv
module gpio_setclr_ctrl
    import gpio_pkg::*;
#(
    parameter int NUM_PINS    = 54,
    parameter int ADDR_W      = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_we,
    input  logic                bus_re,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe
);
    reg_sel_t            sel;
    logic [DATA_W-1:0]   sel_word;
    logic [DATA_W-1:0]   lvl_word;
    logic [NUM_PINS-1:0] level;
    logic [DATA_W-1:0]   rdata_q;

    gpio_addr_dec #(
        .NUM_PINS (NUM_PINS),
        .ADDR_W   (ADDR_W)
    ) u_dec (
        .addr (bus_addr),
        .sel  (sel)
    );

    gpio_fsel_bank #(
        .NUM_PINS (NUM_PINS)
    ) u_fsel (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (bus_we),
        .sel      (sel),
        .wdata    (bus_wdata),
        .rd_word  (sel_word),
        .drive_en (pin_oe)
    );

    gpio_out_latch #(
        .NUM_PINS (NUM_PINS)
    ) u_latch (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (bus_we),
        .sel      (sel),
        .wdata    (bus_wdata),
        .drive_en (pin_oe),
        .pin_out  (pin_out)
    );

    gpio_in_sync #(
        .WIDTH  (NUM_PINS),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (pin_in),
        .dout (level)
    );

    always_comb begin
        lvl_word = '0;
        for (int p = 0; p < NUM_PINS; p++) begin
            if (int'(sel.idx) == p / DATA_W) begin
                lvl_word[p % DATA_W] = level[p];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else if (bus_re) begin
            case (sel.kind)
                RK_SEL:  rdata_q <= sel_word;
                RK_LVL:  rdata_q <= lvl_word;
                default: rdata_q <= '0;
            endcase
        end
    end

    assign bus_rdata = rdata_q;

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pin_oe == '0 && pin_out == '0 && bus_rdata == '0));

    // R6
    setclr_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_re && (sel.kind == RK_SET || sel.kind == RK_CLR)) |=> (bus_rdata == '0));

    // R9
    rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_re |=> $stable(bus_rdata));

    // R10
    unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_re && sel.kind == RK_NONE) |=> (bus_rdata == '0));

endmodule

// File: tb/tb_gpio_setclr_ctrl.sv
module tb_gpio_setclr_ctrl;

    localparam int N  = 54;
    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_we = 1'b0;
    logic          bus_re = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [N-1:0]  pin_in = '0;
    logic [N-1:0]  pin_out;
    logic [N-1:0]  pin_oe;

    int total = 0;
    int bad   = 0;

    logic [2:0]   fsel_m [N];
    logic [N-1:0] lat_m;

    always #2 clk = ~clk;

    gpio_setclr_ctrl #(
        .NUM_PINS    (N),
        .ADDR_W      (AW),
        .SYNC_STAGES (2)
    ) dut (
        .clk       (clk),
        .rst       (rst),
        .bus_we    (bus_we),
        .bus_re    (bus_re),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] sel_word(input int r);
        logic [31:0] w;
        w = '0;
        for (int s = 0; s < 10; s++) begin
            if (r * 10 + s < N) w[3*s +: 3] = fsel_m[r*10 + s];
        end
        return w;
    endfunction

    function automatic logic [N-1:0] oe_exp();
        logic [N-1:0] v;
        for (int p = 0; p < N; p++) v[p] = (fsel_m[p] == 3'b001);
        return v;
    endfunction

    function automatic logic [N-1:0] out_exp();
        return oe_exp() & lat_m;
    endfunction

    task automatic model_write(input int wa, input logic [31:0] d);
        if (wa < 6) begin
            for (int s = 0; s < 10; s++) begin
                if (wa * 10 + s < N) fsel_m[wa*10 + s] = d[3*s +: 3];
            end
        end else if (wa == 7 || wa == 8) begin
            for (int i = 0; i < 32; i++) begin
                if ((wa - 7) * 32 + i < N && d[i]) lat_m[(wa-7)*32 + i] = 1'b1;
            end
        end else if (wa == 10 || wa == 11) begin
            for (int i = 0; i < 32; i++) begin
                if ((wa - 10) * 32 + i < N && d[i]) lat_m[(wa-10)*32 + i] = 1'b0;
            end
        end
    endtask

    task automatic wr(input int wa, input logic [31:0] d);
        @(negedge clk);
        bus_we    = 1'b1;
        bus_addr  = AW'(wa);
        bus_wdata = d;
        @(negedge clk);
        bus_we    = 1'b0;
        model_write(wa, d);
    endtask

    task automatic rd(input int wa, output logic [31:0] d);
        @(negedge clk);
        bus_re   = 1'b1;
        bus_addr = AW'(wa);
        @(negedge clk);
        bus_re   = 1'b0;
        d        = bus_rdata;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0]  d;
        logic [N-1:0] pat;

        for (int p = 0; p < N; p++) fsel_m[p] = 3'b000;
        lat_m = '0;

        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 pin_oe", 64'(pin_oe), 64'd0);
        chk("R1 pin_out", 64'(pin_out), 64'd0);
        chk("R1 bus_rdata", 64'(bus_rdata), 64'd0);
        for (int r = 0; r < 6; r++) begin
            rd(r, d);
            chk("R1 fsel word", 64'(d), 64'd0);
        end

        // R2 / R3 sweep: every pin, every function code
        for (int p = 0; p < N; p++) begin
            for (int c = 0; c < 8; c++) begin
                wr(p / 10, 32'(c) << (3 * (p % 10)));
                rd(p / 10, d);
                chk("R2 fsel readback", 64'(d), 64'(sel_word(p / 10)));
                chk("R3 pin_oe", 64'(pin_oe), 64'(oe_exp()));
            end
        end

        // R2 masking of unused bits, R3 code 111 undriven
        for (int r = 0; r < 6; r++) begin
            wr(r, 32'hFFFF_FFFF);
            rd(r, d);
            chk("R2 fsel all-ones", 64'(d), 64'(sel_word(r)));
        end
        chk("R3 code 111 undriven", 64'(pin_oe), 64'd0);

        // all pins to output
        for (int r = 0; r < 6; r++) wr(r, 32'h0924_9249);
        chk("R3 all outputs", 64'(pin_oe), 64'(oe_exp()));

        // R4 / R5 walking single bit
        for (int p = 0; p < N; p++) begin
            wr(7 + p / 32, 32'd1 << (p % 32));
            chk("R4 single set", 64'(pin_out), 64'(out_exp()));
            wr(10 + p / 32, 32'd1 << (p % 32));
            chk("R5 single clear", 64'(pin_out), 64'(out_exp()));
        end

        // R4 / R5 multi-bit and zero writes
        wr(7, 32'hA5A5_A5A5);
        wr(8, 32'hFFFF_FFFF);
        chk("R4 multi set", 64'(pin_out), 64'(out_exp()));
        wr(7, 32'h0);
        wr(8, 32'h0);
        chk("R4 zero set no effect", 64'(pin_out), 64'(out_exp()));
        wr(10, 32'h0);
        wr(11, 32'h0);
        chk("R5 zero clear no effect", 64'(pin_out), 64'(out_exp()));
        wr(10, 32'h0F0F_0F0F);
        wr(11, 32'h0012_3456);
        chk("R5 multi clear", 64'(pin_out), 64'(out_exp()));

        // R6 set and clear words read zero
        foreach (d[i]) begin end
        rd(7, d);  chk("R6 set0 read", 64'(d), 64'd0);
        rd(8, d);  chk("R6 set1 read", 64'(d), 64'd0);
        rd(10, d); chk("R6 clr0 read", 64'(d), 64'd0);
        rd(11, d); chk("R6 clr1 read", 64'(d), 64'd0);

        // R7 latch follows writes while input, appears on switch to output
        for (int r = 0; r < 6; r++) wr(r, 32'h0);
        chk("R7 inputs undriven", 64'(pin_out), 64'd0);
        wr(10, 32'hFFFF_FFFF);
        wr(11, 32'hFFFF_FFFF);
        wr(7, 32'h1234_5678);
        wr(8, 32'h002A_AAAA);
        chk("R7 no change while input", 64'(pin_out), 64'd0);
        wr(0, 32'h0924_9249);
        chk("R7 first ten pins out", 64'(pin_out), 64'(lat_m & 54'h3FF));
        for (int r = 1; r < 6; r++) wr(r, 32'h0924_9249);
        chk("R7 held latch appears", 64'(pin_out), 64'(lat_m));

        // R8 synchronizer latency
        pat = 54'h2A_5A5A_C3C3_0F0F;
        @(negedge clk);
        pin_in   = pat;
        bus_re   = 1'b1;
        bus_addr = AW'(13);
        @(negedge clk);
        chk("R8 edge1 old", 64'(bus_rdata), 64'd0);
        @(negedge clk);
        chk("R8 edge2 old", 64'(bus_rdata), 64'd0);
        @(negedge clk);
        chk("R8 edge3 new", 64'(bus_rdata), 64'(pat[31:0]));
        bus_re = 1'b0;

        // R9 hold while strobe low
        pin_in = ~pat;
        repeat (5) @(negedge clk);
        chk("R9 rdata held", 64'(bus_rdata), 64'(pat[31:0]));

        // R8 level patterns on both words
        for (int k = 0; k < 6; k++) begin
            pat = (k == 0) ? '0 : (k == 1) ? '1 : (54'h1 << (k * 9)) ^ {N{k[0]}};
            @(negedge clk);
            pin_in = pat;
            repeat (3) @(negedge clk);
            rd(13, d);
            chk("R8 level low word", 64'(d), 64'(pat[31:0]));
            rd(14, d);
            chk("R8 level high word", 64'(d), 64'({10'd0, pat[53:32]}));
        end

        // R10 unmapped addresses
        for (int i = 0; i < 8; i++) begin
            int wa;
            wa = (i == 0) ? 6 : (i == 1) ? 9 : (i == 2) ? 12 : (i == 3) ? 15 :
                 (i == 4) ? 16 : (i == 5) ? 31 : (i == 6) ? 40 : 63;
            wr(wa, 32'hFFFF_FFFF);
            rd(wa, d);
            chk("R10 unmapped read", 64'(d), 64'd0);
        end
        chk("R10 pins unchanged", 64'(pin_out), 64'(out_exp()));
        chk("R10 oe unchanged", 64'(pin_oe), 64'(oe_exp()));
        for (int r = 0; r < 6; r++) begin
            rd(r, d);
            chk("R10 fsel unchanged", 64'(d), 64'(sel_word(r)));
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule